// File: doc/BRIEF.md
# Macrocell Register Preload and Observe Controller

This block wraps a group of macrocell flip-flops with two test modes. A preload strobe writes every flip-flop from the pin data bus in a single clock, so a functional test can start from any state, including illegal ones. An observe request turns on every pin driver, whatever its configured enable, so the contents of buried flip-flops can be read from the pins. While either mode is in force, cells configured as combinational stop passing their sum-term input and show their flip-flop instead. They return to their live combinational value as soon as the mode ends.

Each cell is configured as a D flip-flop, a T flip-flop or a combinational cell. Its pin driver is always off, always on, or follows one of two enable terms shared by its half of the group. A block-wide clear term and a block-wide set term act on the flip-flops at each clock edge with priority over a preload. This lets a preloaded state that asserts those terms be seen to lose its data. Anything built outside the block from combinational feedback, such as a latch, sees the forced flip-flop value during test. It has to be driven to a known state afterwards before it is checked.

Top module: `mc_test_access`

## Requirements
- R1: While `rst_n` is low every flip-flop reads 0 and `test_active` is 0. Pin enables then follow the configuration alone.
- R2: In normal operation, on each clock edge a D cell loads its `cell_d` bit and a T cell inverts its flip-flop where its `cell_d` bit is 1. A combinational cell's flip-flop holds.
- R3: A clock edge at which `preload_req` is 1 loads every flip-flop from `pin_in`, whatever the cell kind. While `preload_req` is 1, all of `pin_oe` is 0.
- R4: From the edge that samples `observe_req` at 1 (with no preload), every pin enable is 1 and every `pin_out` bit shows its flip-flop. At such edges all flip-flops hold.
- R5: The first edge that samples both requests at 0 returns the enables to their configured values and clears `test_active`.
- R6: If both requests are 1 at an edge, preload wins. The flip-flops load `pin_in`, and the observe override does not take effect after that edge.
- R7: While `test_active` is 1, a combinational cell drives its flip-flop value on `pin_out` and its `cell_d` bit has no effect. Once `test_active` is 0, its `pin_out` follows `cell_d` again within the same cycle.
- R8: At an edge, `clr_term` forces every flip-flop to 0 and `set_term` forces every flip-flop to 1. Clear beats set, and both beat a preload.
- R9: Enable selection for cell i uses the 2-bit field `cfg_oe[2i+1:2i]`. The codes are: 0 off, 1 on, 2 first shared term, 3 second shared term. Cells below CELLS/2 use `oe_term[1:0]`, and the upper cells use `oe_term[3:2]`, with bit 0 of each pair as the first term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flip-flop clock, rising edge |
| rst_n | input | 1 | Asynchronous power-up clear, active low |
| preload_req | input | 1 | Preload strobe |
| observe_req | input | 1 | Observe request |
| pin_in | input | CELLS | Data read from the pins |
| cell_d | input | CELLS | Sum-term value of each cell |
| cfg_comb | input | CELLS | 1 marks a combinational cell |
| cfg_tff | input | CELLS | 1 marks a T flip-flop (registered cells) |
| cfg_oe | input | 2*CELLS | Enable select code per cell |
| oe_term | input | 4 | Shared enable terms, two per half |
| clr_term | input | 1 | Block-wide clear term |
| set_term | input | 1 | Block-wide set term |
| reg_q | output | CELLS | Flip-flop contents |
| pin_out | output | CELLS | Value driven toward each pin |
| pin_oe | output | CELLS | Pin driver enable |
| test_active | output | 1 | A test mode is in force |

## Verification
Flip-flop results from a preload, a normal update, a clear or a set are due one edge after the inputs are applied. The bench drives inputs at the falling edge and reads them at the next falling edge. The pin-enable blanking during a preload is combinational and is read in the same half cycle as the strobe. The observe override and the combinational forcing follow the registered mode, so they appear one edge after a request and leave one edge after it drops. The priority case is read just after the shared edge, with the requests already lowered, so that an observe override that wrongly took effect would show on `pin_oe`.

// File: rtl/mc_test_pkg.sv
package mc_test_pkg;

  typedef enum logic [1:0] {
    TM_NORMAL  = 2'd0,
    TM_LOAD    = 2'd1,
    TM_OBSERVE = 2'd2
  } tmode_e;

  typedef enum logic [1:0] {
    OE_OFF   = 2'd0,
    OE_ON    = 2'd1,
    OE_TERM0 = 2'd2,
    OE_TERM1 = 2'd3
  } oesel_e;

  // Next value of a registered cell: D copies, T toggles on 1.
  function automatic logic next_bit(input logic q, input logic d, input logic tff);
    return tff ? (q ^ d) : d;
  endfunction

  // Configured enable from select code and the pair of shared terms.
  function automatic logic oe_pick(input oesel_e sel, input logic [1:0] terms);
    case (sel)
      OE_OFF:   return 1'b0;
      OE_ON:    return 1'b1;
      OE_TERM0: return terms[0];
      default:  return terms[1];
    endcase
  endfunction

endpackage

// File: rtl/mc_mode_ctrl.sv
module mc_mode_ctrl
  import mc_test_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   preload_req,
  input  logic   observe_req,
  output logic   load_now,
  output logic   hold_now,
  output logic   force_on,
  output logic   obs_override,
  output tmode_e mode_q
);
  tmode_e mode_d;

  always_comb begin
    if (preload_req)      mode_d = TM_LOAD;
    else if (observe_req) mode_d = TM_OBSERVE;
    else                  mode_d = TM_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= TM_NORMAL;
    else        mode_q <= mode_d;
  end

  assign load_now     = preload_req;
  assign hold_now     = observe_req & ~preload_req;
  assign force_on     = (mode_q != TM_NORMAL);
  assign obs_override = (mode_q == TM_OBSERVE);

  // R6: preload wins over observe
  a_r6_preload_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_req && observe_req) |=> (mode_q == TM_LOAD));

  // R5: no request ends the test mode at the next edge
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_req && !observe_req) |=> !force_on);

endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_test_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_term,
  input  logic       set_term,
  input  logic       load_now,
  input  logic       hold_now,
  input  logic       force_on,
  input  logic       obs_override,
  input  logic       is_comb,
  input  logic       is_tff,
  input  logic       d_in,
  input  logic       pin_bit,
  input  logic [1:0] oe_sel,
  input  logic [1:0] oe_terms,
  output logic       q,
  output logic       pout,
  output logic       poe
);
  logic sum_live;
  logic cfg_en;
  logic upd_en;

  // Sum term reaches the pin only for a combinational cell outside test.
  assign sum_live = (is_comb & ~force_on) ? d_in : 1'b0;
  assign upd_en   = ~hold_now & ~is_comb;
  assign cfg_en   = oe_pick(oesel_e'(oe_sel), oe_terms);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (clr_term) q <= 1'b0;
    else if (set_term) q <= 1'b1;
    else if (load_now) q <= pin_bit;
    else if (upd_en)   q <= next_bit(q, d_in, is_tff);
  end

  assign pout = (is_comb & ~force_on) ? sum_live : q;
  assign poe  = load_now ? 1'b0 : (obs_override ? 1'b1 : cfg_en);

  // R3: a preload edge writes the pin value
  a_r3_preload_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !clr_term && !set_term) |=> (q == $past(pin_bit)));

  // R8: clear dominates everything
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_term |=> (q == 1'b0));

  // R8: set dominates preload
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_term && !clr_term) |=> (q == 1'b1));

  // R4: observe edges hold the flip-flop
  a_r4_observe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_now && !clr_term && !set_term) |=> $stable(q));

endmodule

// File: rtl/mc_test_access.sv
module mc_test_access
  import mc_test_pkg::*;
#(
  parameter int CELLS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               preload_req,
  input  logic               observe_req,
  input  logic [CELLS-1:0]   pin_in,
  input  logic [CELLS-1:0]   cell_d,
  input  logic [CELLS-1:0]   cfg_comb,
  input  logic [CELLS-1:0]   cfg_tff,
  input  logic [2*CELLS-1:0] cfg_oe,
  input  logic [3:0]         oe_term,
  input  logic               clr_term,
  input  logic               set_term,
  output logic [CELLS-1:0]   reg_q,
  output logic [CELLS-1:0]   pin_out,
  output logic [CELLS-1:0]   pin_oe,
  output logic               test_active
);
  localparam int HALF = CELLS / 2;

  logic   load_now, hold_now, force_on, obs_override;
  tmode_e mode_q;

  mc_mode_ctrl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .preload_req  (preload_req),
    .observe_req  (observe_req),
    .load_now     (load_now),
    .hold_now     (hold_now),
    .force_on     (force_on),
    .obs_override (obs_override),
    .mode_q       (mode_q)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam int BANK = (i < HALF) ? 0 : 1;
    mc_cell u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_term     (clr_term),
      .set_term     (set_term),
      .load_now     (load_now),
      .hold_now     (hold_now),
      .force_on     (force_on),
      .obs_override (obs_override),
      .is_comb      (cfg_comb[i]),
      .is_tff       (cfg_tff[i]),
      .d_in         (cell_d[i]),
      .pin_bit      (pin_in[i]),
      .oe_sel       (cfg_oe[2*i +: 2]),
      .oe_terms     (oe_term[2*BANK +: 2]),
      .q            (reg_q[i]),
      .pout         (pin_out[i]),
      .poe          (pin_oe[i])
    );
  end

  assign test_active = force_on;

  // R3: pins are inputs during a preload strobe
  a_r3_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    preload_req |-> (pin_oe == '0));

  // R4: observe exposes every flip-flop on an enabled pin
  a_r4_observe_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (observe_req && !preload_req) |=> (preload_req || ((pin_oe == '1) && (pin_out == reg_q))));

  // R7: combinational cells show their flip-flop during test
  a_r7_forced_registered: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |-> ((pin_out & cfg_comb) == (reg_q & cfg_comb)));

endmodule

// File: tb/sim_mc_test_access.sv
`timescale 1ns/1ps
module sim_mc_test_access;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        preload_req = 1'b0, observe_req = 1'b0;
  logic [15:0] pin_in = '0, cell_d = '0, cfg_comb, cfg_tff;
  logic [31:0] cfg_oe;
  logic [3:0]  oe_term;
  logic        clr_term = 1'b0, set_term = 1'b0;
  logic [15:0] reg_q, pin_out, pin_oe;
  logic        test_active;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mc_test_access #(.CELLS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .preload_req(preload_req), .observe_req(observe_req),
    .pin_in(pin_in), .cell_d(cell_d), .cfg_comb(cfg_comb), .cfg_tff(cfg_tff),
    .cfg_oe(cfg_oe), .oe_term(oe_term), .clr_term(clr_term), .set_term(set_term),
    .reg_q(reg_q), .pin_out(pin_out), .pin_oe(pin_oe), .test_active(test_active)
  );

  // rows: {preload value, sum-term data}
  localparam logic [31:0] VEC [0:3] = '{
    32'hA5C3_0F0F, 32'h0000_FFFF, 32'hFFFF_00FF, 32'h1234_F0F0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // configured enable per R9, written from the code table
  function automatic logic [15:0] cfg_enables(input logic [31:0] oe, input logic [3:0] t);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      int code = int'(oe[2*i +: 2]);
      int base = (i >= 8) ? 2 : 0;
      if (code == 0)      r[i] = 1'b0;
      else if (code == 1) r[i] = 1'b1;
      else                r[i] = t[base + code - 2];
    end
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] en_exp, pre, d, expq, qs;
    cfg_comb = 16'h000F;
    cfg_tff  = 16'h00F0;
    oe_term  = 4'b0110;
    for (int i = 0; i < 16; i++) cfg_oe[2*i +: 2] = 2'(i % 4);
    en_exp = cfg_enables(cfg_oe, oe_term);

    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 q", {16'h0, reg_q}, 32'h0);
    chk("R1 active", {31'h0, test_active}, 32'h0);
    chk("R9 oe cfg", {16'h0, pin_oe}, {16'h0, en_exp});
    rst_n = 1'b1;
    step();

    // R3/R2/R7: table walk
    for (int k = 0; k < 4; k++) begin
      pre = VEC[k][31:16];
      d   = VEC[k][15:0];
      pin_in = pre; preload_req = 1'b1; cell_d = ~d;
      #0.5;
      chk("R3 pins off", {16'h0, pin_oe}, 32'h0);
      step();
      chk("R3 preload", {16'h0, reg_q}, {16'h0, pre});
      preload_req = 1'b0;
      #0.5;
      chk("R7 forced comb", {16'h0, pin_out & cfg_comb}, {16'h0, pre & cfg_comb});
      cell_d = d;
      step();
      expq = (pre & cfg_comb) | (~cfg_comb & cfg_tff & (pre ^ d)) | (~cfg_comb & ~cfg_tff & d);
      chk("R2 update", {16'h0, reg_q}, {16'h0, expq});
      chk("R7 comb live", {16'h0, pin_out & cfg_comb}, {16'h0, d & cfg_comb});
    end

    // R4/R5/R7: observe
    qs = reg_q;
    cell_d = 16'h5A5A; observe_req = 1'b1;
    step();
    chk("R4 all on", {16'h0, pin_oe}, 32'h0000_FFFF);
    chk("R4 shows q", {16'h0, pin_out}, {16'h0, qs});
    chk("R4 active", {31'h0, test_active}, 32'h1);
    cell_d = 16'hC3C3;
    step();
    chk("R4 hold", {16'h0, reg_q}, {16'h0, qs});
    chk("R7 d ignored", {16'h0, pin_out & cfg_comb}, {16'h0, qs & cfg_comb});
    observe_req = 1'b0;
    step();
    chk("R5 oe back", {16'h0, pin_oe}, {16'h0, en_exp});
    chk("R5 inactive", {31'h0, test_active}, 32'h0);
    chk("R7 restored", {16'h0, pin_out & cfg_comb}, {16'h0, 16'hC3C3 & cfg_comb});

    // R6: both requests
    pin_in = 16'h6E21; preload_req = 1'b1; observe_req = 1'b1;
    step();
    chk("R6 loaded", {16'h0, reg_q}, 32'h0000_6E21);
    preload_req = 1'b0; observe_req = 1'b0;
    #0.5;
    chk("R6 no override", {16'h0, pin_oe}, {16'h0, en_exp});
    step();

    // R8: clear/set beat preload
    pin_in = 16'hFFFF; preload_req = 1'b1; clr_term = 1'b1;
    step();
    chk("R8 clear", {16'h0, reg_q}, 32'h0);
    pin_in = 16'h0000; clr_term = 1'b0; set_term = 1'b1;
    step();
    chk("R8 set", {16'h0, reg_q}, 32'h0000_FFFF);
    clr_term = 1'b1;
    step();
    chk("R8 clear over set", {16'h0, reg_q}, 32'h0);
    clr_term = 1'b0; set_term = 1'b0; preload_req = 1'b0;

    // R9: other shared-term values
    oe_term = 4'b1001;
    #0.5;
    chk("R9 terms", {16'h0, pin_oe}, {16'h0, cfg_enables(cfg_oe, oe_term)});
    step();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule